// File: doc/BRIEF.md
# Delayed-Transfer Program Counter Sequencer

This block keeps the pair of program counters for an in-order core whose control transfers take effect one instruction late. The register `pc` holds the address of the instruction now being executed. The register `npc` holds the address that comes after it. On every advancing cycle the core presents the class of the instruction at `pc`, together with these inputs:

- its word displacements;
- its annul bit;
- a single condition-true bit, already evaluated elsewhere;
- a register-indirect target, already summed elsewhere.

The sequencer moves `pc` to `npc` and loads `npc` with either the sequential successor or the transfer target. The instruction that follows a transfer, the delay slot, is therefore always fetched.

For each branch the block also decides whether the delay slot must be annulled. It records that decision in a flag that travels with the slot. A slot that arrives with the flag set is squashed: its class is ignored, and it only steps the counters. A register-indirect target with nonzero low bits is rejected. In that case both counters hold and a one-cycle misalignment pulse is raised for the trap logic outside the block.

Top module: `delay_pc_sequencer`

## Requirements
- R1: While `rst_n` is low, and after its release until the first advance, `pc_o` is 0, `npc_o` is 4, and `annul_slot_o` and `misalign_o` are 0.
- R2: Class codes on `cls_i` are: 0 sequential, 1 conditional branch, 2 branch-always, 3 branch-never, 4 call, 5 register jump. Codes 6 and 7 act as sequential. For a sequential instruction with `adv_i` high, `pc` takes the old `npc` and `npc` becomes old `npc`+4. With `adv_i` low, `pc`, `npc` and `annul_slot_o` hold. `fetch_addr_o` always equals `pc_o`, and both counters stay word aligned.
- R3: For a conditional branch with `cond_true_i`=1, `pc` takes old `npc` and `npc` becomes the branch's own `pc` plus the 22-bit displacement shifted left by two and sign-extended. `annul_slot_o` becomes 0 whatever the annul bit is.
- R4: For a conditional branch with `cond_true_i`=0, `npc` becomes old `npc`+4 and `annul_slot_o` takes `annul_bit_i`.
- R5: Branch-always ignores `cond_true_i`, always redirects as in R3, and sets `annul_slot_o` to `annul_bit_i`.
- R6: Branch-never ignores `cond_true_i`, never redirects, and sets `annul_slot_o` to `annul_bit_i`.
- R7: For a call, `npc` becomes the call's own `pc` plus the 30-bit displacement with two zero bits appended, taken modulo 2^32. `annul_slot_o` becomes 0.
- R8: For a register jump with both low target bits zero, `npc` becomes `reg_target_i` and `annul_slot_o` becomes 0.
- R9: For a register jump with either low target bit set, `pc` and `npc` hold, `annul_slot_o` becomes 0, and `misalign_o` is high for exactly the next cycle.
- R10: An instruction presented with `adv_i`=1 while `annul_slot_o`=1 is treated as sequential, whatever its class and other inputs. It clears `annul_slot_o` and never raises `misalign_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Instruction at pc retires this cycle |
| cls_i | input | 3 | Instruction class code |
| disp_br_i | input | 22 | Branch word displacement |
| disp_call_i | input | 30 | Call word displacement |
| annul_bit_i | input | 1 | Annul bit of the branch |
| cond_true_i | input | 1 | Evaluated branch condition |
| reg_target_i | input | 32 | Register-indirect jump target |
| fetch_addr_o | output | 32 | Address of the instruction to fetch/execute |
| pc_o | output | 32 | Current program counter |
| npc_o | output | 32 | Next program counter |
| annul_slot_o | output | 1 | The instruction at pc is annulled |
| misalign_o | output | 1 | Previous jump target was misaligned |

## Verification
In the colliding case, the annul decision of a branch and a control transfer of its own fall in the same cycle, at the branch's delay slot. The bench provokes this by placing a register jump, a call, and a misaligned jump directly in the slot after an annulling not-taken branch and after an annulling branch-always. In that cycle the squash must win. The counters must only step by four, with no redirect and no misalignment pulse, and the annul flag must drop so that the instruction after the squashed slot runs normally.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [2:0] {
    XC_SEQ   = 3'd0,
    XC_BCOND = 3'd1,
    XC_BALW  = 3'd2,
    XC_BNEV  = 3'd3,
    XC_CALL  = 3'd4,
    XC_JUMP  = 3'd5
  } xfer_cls_e;

  typedef enum logic [1:0] {
    TS_SEQ  = 2'd0,
    TS_BR   = 2'd1,
    TS_CALL = 2'd2,
    TS_REG  = 2'd3
  } tgt_sel_e;

  typedef struct packed {
    tgt_sel_e sel;
    logic     hold;
    logic     annul_nxt;
    logic     misalign;
  } xfer_dec_t;

endpackage

// File: rtl/dpc_target_calc.sv
module dpc_target_calc #(
  parameter int XLEN  = 32,
  parameter int BDISP = 22,
  parameter int CDISP = 30
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [BDISP-1:0] disp_br,
  input  logic [CDISP-1:0] disp_call,
  output logic [XLEN-1:0]  br_tgt,
  output logic [XLEN-1:0]  call_tgt
);
  localparam int BW = BDISP + 2;
  localparam int CW = CDISP + 2;

  logic [BW-1:0]   br_word;
  logic [CW-1:0]   call_word;
  logic [XLEN-1:0] br_off;
  logic [XLEN-1:0] call_off;

  assign br_word   = {disp_br, 2'b00};
  assign call_word = {disp_call, 2'b00};

  generate
    if (BW >= XLEN) begin : g_br_trunc
      assign br_off = br_word[XLEN-1:0];
    end else begin : g_br_sext
      assign br_off = {{(XLEN-BW){br_word[BW-1]}}, br_word};
    end
    if (CW >= XLEN) begin : g_call_trunc
      assign call_off = call_word[XLEN-1:0];
    end else begin : g_call_zext
      assign call_off = {{(XLEN-CW){1'b0}}, call_word};
    end
  endgenerate

  assign br_tgt   = pc + br_off;
  assign call_tgt = pc + call_off;
endmodule

// File: rtl/dpc_decide.sv
module dpc_decide
  import dpc_pkg::*;
(
  input  logic [2:0] cls,
  input  logic       slot_annulled,
  input  logic       annul_bit,
  input  logic       cond_true,
  input  logic       tgt_unaligned,
  output xfer_dec_t  dec
);
  xfer_cls_e eff;

  always_comb begin
    if (slot_annulled) begin
      eff = XC_SEQ;
    end else begin
      case (cls)
        3'd1:    eff = XC_BCOND;
        3'd2:    eff = XC_BALW;
        3'd3:    eff = XC_BNEV;
        3'd4:    eff = XC_CALL;
        3'd5:    eff = XC_JUMP;
        default: eff = XC_SEQ;
      endcase
    end
  end

  always_comb begin
    dec.sel       = TS_SEQ;
    dec.hold      = 1'b0;
    dec.annul_nxt = 1'b0;
    dec.misalign  = 1'b0;
    case (eff)
      XC_BCOND: begin
        if (cond_true) dec.sel = TS_BR;
        else           dec.annul_nxt = annul_bit;
      end
      XC_BALW: begin
        dec.sel       = TS_BR;
        dec.annul_nxt = annul_bit;
      end
      XC_BNEV: begin
        dec.annul_nxt = annul_bit;
      end
      XC_CALL: begin
        dec.sel = TS_CALL;
      end
      XC_JUMP: begin
        if (tgt_unaligned) begin
          dec.hold     = 1'b1;
          dec.misalign = 1'b1;
        end else begin
          dec.sel = TS_REG;
        end
      end
      default: begin
        dec.sel = TS_SEQ;
      end
    endcase
  end
endmodule

// File: rtl/dpc_pc_regs.sv
module dpc_pc_regs #(
  parameter int XLEN     = 32,
  parameter int RESET_PC = 0,
  parameter int STEP     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            hold,
  input  logic [XLEN-1:0] npc_nxt,
  input  logic            annul_nxt,
  input  logic            mis_nxt,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] npc_q,
  output logic            annul_q,
  output logic            mis_q
);
  localparam logic [XLEN-1:0] PC_RST  = XLEN'(RESET_PC);
  localparam logic [XLEN-1:0] NPC_RST = XLEN'(RESET_PC + STEP);

  logic [XLEN-1:0] pc_d, npc_d;
  logic            annul_d, mis_d;
  logic            move;

  assign move = en & ~hold;

  always_comb begin
    pc_d    = move ? npc_q   : pc_q;
    npc_d   = move ? npc_nxt : npc_q;
    annul_d = en   ? annul_nxt : annul_q;
    mis_d   = en & mis_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= PC_RST;
      npc_q   <= NPC_RST;
      annul_q <= 1'b0;
      mis_q   <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      npc_q   <= npc_d;
      annul_q <= annul_d;
      mis_q   <= mis_d;
    end
  end
endmodule

// File: rtl/delay_pc_sequencer.sv
module delay_pc_sequencer
  import dpc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int BDISP    = 22,
  parameter int CDISP    = 30,
  parameter int RESET_PC = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic [2:0]       cls_i,
  input  logic [BDISP-1:0] disp_br_i,
  input  logic [CDISP-1:0] disp_call_i,
  input  logic             annul_bit_i,
  input  logic             cond_true_i,
  input  logic [XLEN-1:0]  reg_target_i,
  output logic [XLEN-1:0]  fetch_addr_o,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  npc_o,
  output logic             annul_slot_o,
  output logic             misalign_o
);
  localparam int ALIGN_BITS = 2;
  localparam int STEP       = 1 << ALIGN_BITS;

  logic [XLEN-1:0] pc_q, npc_q;
  logic            annul_q, mis_q;
  logic [XLEN-1:0] br_tgt, call_tgt, seq_tgt, npc_nxt;
  logic            unaligned;
  xfer_dec_t       dec;

  assign unaligned = |reg_target_i[ALIGN_BITS-1:0];
  assign seq_tgt   = npc_q + XLEN'(STEP);

  dpc_target_calc #(.XLEN(XLEN), .BDISP(BDISP), .CDISP(CDISP)) u_tgt (
    .pc        (pc_q),
    .disp_br   (disp_br_i),
    .disp_call (disp_call_i),
    .br_tgt    (br_tgt),
    .call_tgt  (call_tgt)
  );

  dpc_decide u_dec (
    .cls           (cls_i),
    .slot_annulled (annul_q),
    .annul_bit     (annul_bit_i),
    .cond_true     (cond_true_i),
    .tgt_unaligned (unaligned),
    .dec           (dec)
  );

  always_comb begin
    case (dec.sel)
      TS_BR:   npc_nxt = br_tgt;
      TS_CALL: npc_nxt = call_tgt;
      TS_REG:  npc_nxt = reg_target_i;
      default: npc_nxt = seq_tgt;
    endcase
  end

  dpc_pc_regs #(.XLEN(XLEN), .RESET_PC(RESET_PC), .STEP(STEP)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (adv_i),
    .hold      (dec.hold),
    .npc_nxt   (npc_nxt),
    .annul_nxt (dec.annul_nxt),
    .mis_nxt   (dec.misalign),
    .pc_q      (pc_q),
    .npc_q     (npc_q),
    .annul_q   (annul_q),
    .mis_q     (mis_q)
  );

  assign pc_o         = pc_q;
  assign npc_o        = npc_q;
  assign fetch_addr_o = pc_q;
  assign annul_slot_o = annul_q;
  assign misalign_o   = mis_q;
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int XLEN  = 32,
  parameter int BDISP = 22,
  parameter int CDISP = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adv_i,
  input logic [2:0]       cls_i,
  input logic [BDISP-1:0] disp_br_i,
  input logic [CDISP-1:0] disp_call_i,
  input logic             annul_bit_i,
  input logic             cond_true_i,
  input logic [XLEN-1:0]  reg_target_i,
  input logic [XLEN-1:0]  fetch_addr_o,
  input logic [XLEN-1:0]  pc_o,
  input logic [XLEN-1:0]  npc_o,
  input logic             annul_slot_o,
  input logic             misalign_o
);
  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> ($stable(pc_o) && $stable(npc_o) && $stable(annul_slot_o)));

  // R2
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_o[1:0] == 2'b00) && (npc_o[1:0] == 2'b00) && (fetch_addr_o == pc_o));

  // R3
  taken_no_annul_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !annul_slot_o && cls_i == 3'd1 && cond_true_i) |=> !annul_slot_o);

  // R7
  call_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !annul_slot_o && cls_i == 3'd4)
      |=> (npc_o == $past(pc_o + XLEN'({disp_call_i, 2'b00})) && !annul_slot_o));

  // R8
  jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !annul_slot_o && cls_i == 3'd5 && reg_target_i[1:0] == 2'b00)
      |=> (npc_o == $past(reg_target_i) && pc_o == $past(npc_o)));

  // R9
  misalign_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !annul_slot_o && cls_i == 3'd5 && reg_target_i[1:0] != 2'b00)
      |=> (misalign_o && $stable(pc_o) && $stable(npc_o) && !annul_slot_o));

  // R10
  annul_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && annul_slot_o) |=> (!annul_slot_o && !misalign_o && pc_o == $past(npc_o)));
endmodule

bind delay_pc_sequencer dpc_checker #(.XLEN(XLEN), .BDISP(BDISP), .CDISP(CDISP)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .adv_i        (adv_i),
  .cls_i        (cls_i),
  .disp_br_i    (disp_br_i),
  .disp_call_i  (disp_call_i),
  .annul_bit_i  (annul_bit_i),
  .cond_true_i  (cond_true_i),
  .reg_target_i (reg_target_i),
  .fetch_addr_o (fetch_addr_o),
  .pc_o         (pc_o),
  .npc_o        (npc_o),
  .annul_slot_o (annul_slot_o),
  .misalign_o   (misalign_o)
);

// File: tb/delay_pc_sequencer_tb.sv
module delay_pc_sequencer_tb;
  logic        clk;
  logic        rst_n;
  logic        adv_i;
  logic [2:0]  cls_i;
  logic [21:0] disp_br_i;
  logic [29:0] disp_call_i;
  logic        annul_bit_i;
  logic        cond_true_i;
  logic [31:0] reg_target_i;
  logic [31:0] fetch_addr_o, pc_o, npc_o;
  logic        annul_slot_o, misalign_o;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] npc;
    logic        ann;
    logic        mis;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  logic [31:0] mpc, mnpc;
  logic        mann;

  delay_pc_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .cls_i(cls_i),
    .disp_br_i(disp_br_i), .disp_call_i(disp_call_i),
    .annul_bit_i(annul_bit_i), .cond_true_i(cond_true_i),
    .reg_target_i(reg_target_i), .fetch_addr_o(fetch_addr_o),
    .pc_o(pc_o), .npc_o(npc_o), .annul_slot_o(annul_slot_o),
    .misalign_o(misalign_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic compare(input exp_t e, input string tag);
    checks++;
    if (pc_o !== e.pc || npc_o !== e.npc || annul_slot_o !== e.ann ||
        misalign_o !== e.mis || fetch_addr_o !== e.pc) begin
      errors++;
      $display("FAIL %s: got pc=%h npc=%h fetch=%h ann=%b mis=%b, expected pc=%h npc=%h fetch=%h ann=%b mis=%b",
               tag, pc_o, npc_o, fetch_addr_o, annul_slot_o, misalign_o,
               e.pc, e.npc, e.pc, e.ann, e.mis);
    end
  endtask

  // monitor: pops expected items and compares them away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      compare(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  // driver: applies one instruction, models it from the requirements, pushes the expectation
  task automatic step(input logic adv, input logic [2:0] cls, input logic [21:0] d22,
                      input logic [29:0] d30, input logic a, input logic c,
                      input logic [31:0] tgt, input string tag);
    logic [2:0]  eff;
    logic [31:0] nn, br, cl;
    logic        nann, mis, hold;
    exp_t        e;
    adv_i = adv; cls_i = cls; disp_br_i = d22; disp_call_i = d30;
    annul_bit_i = a; cond_true_i = c; reg_target_i = tgt;
    eff  = mann ? 3'd0 : ((cls > 3'd5) ? 3'd0 : cls);
    br   = mpc + {{8{d22[21]}}, d22, 2'b00};
    cl   = mpc + {d30, 2'b00};
    nn   = mnpc + 32'd4;
    nann = 1'b0; mis = 1'b0; hold = 1'b0;
    case (eff)
      3'd1: if (c) nn = br; else nann = a;
      3'd2: begin nn = br; nann = a; end
      3'd3: nann = a;
      3'd4: nn = cl;
      3'd5: if (tgt[1:0] != 2'b00) begin hold = 1'b1; mis = 1'b1; end else nn = tgt;
      default: ;
    endcase
    @(posedge clk);
    if (!adv) begin
      mis = 1'b0;
    end else if (hold) begin
      mann = 1'b0;
    end else begin
      mpc  = mnpc;
      mnpc = nn;
      mann = nann;
    end
    e.pc = mpc; e.npc = mnpc; e.ann = mann; e.mis = mis;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired before the sequence ended (all requirements)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    exp_t r;
    rst_n = 1'b0; adv_i = 1'b0; cls_i = 3'd0; disp_br_i = '0; disp_call_i = '0;
    annul_bit_i = 1'b0; cond_true_i = 1'b0; reg_target_i = '0;
    mpc = 32'h0; mnpc = 32'h4; mann = 1'b0;
    repeat (3) @(negedge clk);
    r.pc = 32'h0; r.npc = 32'h4; r.ann = 1'b0; r.mis = 1'b0;
    compare(r, "R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare(r, "R1 after release");

    step(1, 3'd0, '0, '0, 0, 0, '0, "R2 sequential");
    step(1, 3'd7, '0, '0, 1, 1, '0, "R2 unused code is sequential");
    step(0, 3'd4, '0, 30'h100, 1, 1, '0, "R2 stall holds");
    step(1, 3'd1, 22'h10, '0, 1, 1, '0, "R3 taken, annul bit ignored");
    step(1, 3'd0, '0, '0, 0, 0, '0, "R3 delay slot executes");
    step(1, 3'd1, 22'h3FFFF0, '0, 0, 1, '0, "R3 taken backward");
    step(1, 3'd0, '0, '0, 0, 0, '0, "R3 slot");
    step(1, 3'd1, 22'h20, '0, 1, 0, '0, "R4 not taken annul=1");
    step(1, 3'd5, '0, '0, 0, 0, 32'h100, "R10 annulled slot jump ignored");
    step(1, 3'd0, '0, '0, 0, 0, '0, "R10 flow resumes");
    step(1, 3'd1, 22'h20, '0, 0, 0, '0, "R4 not taken annul=0");
    step(1, 3'd0, '0, '0, 0, 0, '0, "R4 slot executes");
    step(1, 3'd2, 22'h8, '0, 1, 0, '0, "R5 always annul=1");
    step(1, 3'd4, '0, 30'h40, 0, 0, '0, "R10 annulled slot call ignored");
    step(1, 3'd0, '0, '0, 0, 0, '0, "R5 at target");
    step(1, 3'd2, 22'h4, '0, 0, 0, '0, "R5 always annul=0");
    step(1, 3'd0, '0, '0, 0, 0, '0, "R5 slot executes");
    step(1, 3'd3, 22'h40, '0, 0, 1, '0, "R6 never annul=0");
    step(1, 3'd3, 22'h40, '0, 1, 1, '0, "R6 never annul=1");
    step(1, 3'd0, '0, '0, 0, 0, '0, "R6 annulled slot");
    step(1, 3'd4, '0, 30'h3FFFFFF0, 1, 1, '0, "R7 call wraps");
    step(1, 3'd0, '0, '0, 0, 0, '0, "R7 slot");
    step(1, 3'd5, '0, '0, 1, 1, 32'h0000_2000, "R8 aligned jump");
    step(1, 3'd0, '0, '0, 0, 0, '0, "R8 slot");
    step(1, 3'd5, '0, '0, 0, 0, 32'h0000_3002, "R9 misaligned jump");
    step(1, 3'd0, '0, '0, 0, 0, '0, "R9 pulse ends");
    step(1, 3'd1, 22'h1, '0, 1, 0, '0, "R4 annul before misaligned slot");
    step(1, 3'd5, '0, '0, 0, 0, 32'h0000_0001, "R10 squashed misaligned jump no flag");
    step(1, 3'd0, '0, '0, 0, 0, '0, "R10 after squash");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule